// File: doc/BRIEF.md
# Offset-Binary Distributed-Arithmetic Inner-Product Core

This block computes the inner product of a set of signed coefficient words and a set of signed sample words, the kernel of one output of a small FIR filter, without a multiplier. A lookup table holds precomputed signed sums of the samples, each taken with a plus or minus sign per tap. In each cycle, one bit position taken across all coefficient words, starting at the least significant bit, selects one of these sums. A shift-accumulator weights the selected sums by bit position over the coefficient width. The table holds only half of the sign combinations. The other half is mirrored: the low address bits are inverted under control of the top address bit, and the read value is negated.

The user first writes the table through a synchronous write port. The table values depend only on the samples. The user then presents the coefficient and sample words and pulses `start`. The samples are read once, on the start edge, to form the offset correction constant. A parameter selects how many bit positions are consumed per cycle: one, or two through a second table read port. With two, the run length is halved. The result appears together with a single-cycle `done` and is held until the next result.

Top module: `dafir_core`

## Requirements
- R1: When `done` is high, `y_out` equals the signed sum over taps k of coef_k * samp_k, where coef_k is `coef_in[k*CW +: CW]` and samp_k is `samp_in[k*XW +: XW]`, both two's complement.
- R2: Table entry i, for i from 0 to 2^(N-1)-1, must hold -samp_(N-1) plus the sum over k < N-1 of (+samp_k if bit k of i is 1, else -samp_k), written in EW-bit two's complement. Bit k of each lookup address is the current bit of coefficient k, and the bit positions are taken least significant first.
- R3: A lookup whose tap N-1 bit is 1 uses the stored entry at the inverted low address bits, negated. Coefficient sets with a negative coef_(N-1) therefore still satisfy R1.
- R4: The most significant coefficient bit slice is subtracted, and -(sum of samples) is added exactly once, so extreme coefficients (-2^(CW-1) and 2^(CW-1)-1) give exact results.
- R5: `done` goes high for exactly one cycle, CW/RB clock edges after the edge that accepted `start`.
- R6: `y_out` changes only on the edge that raises `done`, and holds between results.
- R7: Table writes presented while a computation is running are discarded.
- R8: A `start` pulse during a running computation is ignored. The running result and its `done` timing are unchanged.
- R9: With RB=2 (two bit slices per cycle, two table read ports), the result equals the RB=1 result and arrives in CW/2 cycles.
- R10: After reset, `done` is 0 and `y_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| coef_in | input | N*CW | Coefficient words, tap k at bits k*CW |
| samp_in | input | N*XW | Sample words, tap k at bits k*XW, read on the start edge |
| tab_we | input | 1 | Table write enable |
| tab_addr | input | N-1 | Table write index |
| tab_data | input | EW | Table write data, EW = XW+clog2(N)+1 |
| y_out | output | XW+CW+clog2(N) | Signed inner-product result |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest situations to create from the ports are a table write and a second start that arrive in the middle of a run. Both must leave no trace. The stimulus places each of them on a chosen edge inside the run window. It then repeats the computation without reloading the table, so a stray write would surface as a wrong result. The mirrored half of the table is reached by coefficient sets whose last tap is negative, including a run where every slice is mirrored. An instance of the two-slice variant runs on the same inputs, so its earlier result and earlier `done` are checked against the single-slice one.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
   typedef enum logic {ST_IDLE, ST_RUN} run_state_t;

   function automatic int unsigned cnt_width(input int unsigned steps);
      cnt_width = (steps > 1) ? $clog2(steps) : 1;
   endfunction
endpackage

// File: rtl/dafir_lut.sv
module dafir_lut #(
   parameter int N  = 4,
   parameter int EW = 11,
   parameter int RB = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock,
   input  logic             we,
   input  logic [N-2:0]     waddr,
   input  logic [EW-1:0]    wdata,
   input  logic [RB*N-1:0]  slices,
   output logic [RB*EW-1:0] rd
);
   localparam int DEPTH = 1 << (N - 1);

   logic [EW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && !lock) mem[waddr] <= wdata;
   end

   for (genvar r = 0; r < RB; r++) begin : g_port
      logic          flip;
      logic [N-2:0]  idx;
      logic [EW-1:0] raw;
      assign flip = slices[r*N + N - 1];
      assign idx  = slices[r*N +: N-1] ^ {(N-1){flip}};
      assign raw  = mem[idx];
      assign rd[r*EW +: EW] = flip ? (~raw + EW'(1)) : raw;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_frozen
      // R7: the table is frozen while a run is in progress
      assert_tab_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
         lock |=> $stable(mem[i]));
   end
endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
   import dafir_pkg::*;
#(
   parameter int N  = 4,
   parameter int CW = 8,
   parameter int RB = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [N*CW-1:0] coef_in,
   output logic            load,
   output logic            busy,
   output logic            last,
   output logic [RB*N-1:0] slices
);
   localparam int NC   = CW / RB;
   localparam int CNTW = cnt_width(NC);

   run_state_t      state;
   logic [CNTW-1:0] cnt;
   logic [N*CW-1:0] creg;

   assign load = start && (state == ST_IDLE);
   assign busy = (state == ST_RUN);
   assign last = busy && (cnt == CNTW'(NC - 1));

   for (genvar r = 0; r < RB; r++) begin : g_slice
      for (genvar k = 0; k < N; k++) begin : g_tap
         assign slices[r*N + k] = creg[k*CW + r];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         creg  <= '0;
      end else if (load) begin
         state <= ST_RUN;
         cnt   <= '0;
         creg  <= coef_in;
      end else if (busy) begin
         cnt <= cnt + CNTW'(1);
         for (int k = 0; k < N; k++) creg[k*CW +: CW] <= creg[k*CW +: CW] >> RB;
         if (last) state <= ST_IDLE;
      end
   end

   // R8: a run cannot be cut short or restarted
   assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   // R5: a run ends right after its final slice
   assert_run_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);
endmodule

// File: rtl/dafir_acc.sv
module dafir_acc #(
   parameter int CW = 8,
   parameter int EW = 11,
   parameter int RB = 1,
   parameter int HW = 15,
   parameter int YW = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             last,
   input  logic [EW-1:0]    offset,
   input  logic [RB*EW-1:0] parts,
   output logic [YW-1:0]    y_out,
   output logic             done
);
   localparam int FW = HW + CW;

   logic signed [HW-1:0] hi, term, sum_v, nhi;
   logic [CW-1:0]        lo, nlo;
   logic [FW-1:0]        fullv;

   always_comb begin
      term = '0;
      for (int r = 0; r < RB; r++) begin
         logic signed [HW-1:0] p;
         p = {{(HW-EW){parts[r*EW + EW - 1]}}, parts[r*EW +: EW]};
         p = p <<< r;
         if (last && (r == RB - 1)) term = term - p;
         else                       term = term + p;
      end
      sum_v = hi + term;
      nhi   = sum_v >>> RB;
      nlo   = {sum_v[RB-1:0], lo[CW-1:RB]};
      fullv = {nhi, nlo};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi    <= '0;
         lo    <= '0;
         y_out <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            hi <= {{(HW-EW){offset[EW-1]}}, offset};
            lo <= '0;
         end else if (step) begin
            hi <= nhi;
            lo <= nlo;
            if (last) begin
               y_out <= fullv[YW:1];
               done  <= 1'b1;
            end
         end
      end
   end

   // R1: the running sum never leaves the accumulator range
   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (sum_v[HW-1] == sum_v[HW-2]));
endmodule

// File: rtl/dafir_core.sv
module dafir_core #(
   parameter int N  = 4,
   parameter int CW = 8,
   parameter int XW = 8,
   parameter int RB = 1,
   localparam int EW = XW + $clog2(N) + 1,
   localparam int YW = XW + CW + $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [N*CW-1:0] coef_in,
   input  logic [N*XW-1:0] samp_in,
   input  logic            tab_we,
   input  logic [N-2:0]    tab_addr,
   input  logic [EW-1:0]   tab_data,
   output logic [YW-1:0]   y_out,
   output logic            done
);
   localparam int HW = EW + 4;

   if (N < 2) begin : g_bad_n
      $error("dafir_core: N must be at least 2");
   end
   if (RB != 1 && RB != 2) begin : g_bad_rb
      $error("dafir_core: RB must be 1 or 2");
   end
   if ((CW % RB) != 0 || (CW / RB) < 2) begin : g_bad_cw
      $error("dafir_core: CW must be a multiple of RB with at least two steps");
   end

   logic             load, busy, last;
   logic [RB*N-1:0]  slices;
   logic [RB*EW-1:0] parts;
   logic [EW-1:0]    offset;

   always_comb begin
      logic [EW-1:0] acc;
      acc = '0;
      for (int k = 0; k < N; k++)
         acc = acc + {{(EW-XW){samp_in[k*XW + XW - 1]}}, samp_in[k*XW +: XW]};
      offset = ~acc + EW'(1);
   end

   dafir_ctrl #(.N(N), .CW(CW), .RB(RB)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in),
      .load(load), .busy(busy), .last(last), .slices(slices)
   );

   dafir_lut #(.N(N), .EW(EW), .RB(RB)) u_lut (
      .clk(clk), .rst_n(rst_n), .lock(busy), .we(tab_we), .waddr(tab_addr),
      .wdata(tab_data), .slices(slices), .rd(parts)
   );

   dafir_acc #(.CW(CW), .EW(EW), .RB(RB), .HW(HW), .YW(YW)) u_acc (
      .clk(clk), .rst_n(rst_n), .load(load), .step(busy), .last(last),
      .offset(offset), .parts(parts), .y_out(y_out), .done(done)
   );

   // R5: done is a single-cycle pulse
   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: done only closes a run
   assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
   // R6: the result holds between pulses
   assert_y_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(y_out));
endmodule

// File: tb/sim_dafir_core.sv
module sim_dafir_core;
   localparam int CLK_NS = 10;
   localparam int N  = 4;
   localparam int CW = 8;
   localparam int XW = 8;
   localparam int EW = XW + $clog2(N) + 1;
   localparam int YW = XW + CW + $clog2(N);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [N*CW-1:0] coef_in = '0;
   logic [N*XW-1:0] samp_in = '0;
   logic            tab_we = 1'b0;
   logic [N-2:0]    tab_addr = '0;
   logic [EW-1:0]   tab_data = '0;
   logic [YW-1:0]   y0, y1;
   logic            done0, done1;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   int cs[N];
   int xs[N];

   always #(CLK_NS/2) clk = ~clk;

   dafir_core #(.N(N), .CW(CW), .XW(XW), .RB(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in), .samp_in(samp_in),
      .tab_we(tab_we), .tab_addr(tab_addr), .tab_data(tab_data), .y_out(y0), .done(done0));

   dafir_core #(.N(N), .CW(CW), .XW(XW), .RB(2)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in), .samp_in(samp_in),
      .tab_we(tab_we), .tab_addr(tab_addr), .tab_data(tab_data), .y_out(y1), .done(done1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int dot();
      int s = 0;
      for (int k = 0; k < N; k++) s += cs[k] * xs[k];
      return s;
   endfunction

   // R2 table encoding: entry i = -x[N-1] + sum over k<N-1 of (bit k of i ? +x[k] : -x[k])
   function automatic logic [EW-1:0] tab_entry(input int i);
      int v = -xs[N-1];
      for (int k = 0; k < N - 1; k++) v += ((i >> k) & 1) ? xs[k] : -xs[k];
      return EW'(v);
   endfunction

   task automatic load_table();
      for (int i = 0; i < (1 << (N - 1)); i++) begin
         @(negedge clk);
         tab_we = 1'b1; tab_addr = (N-1)'(i); tab_data = tab_entry(i);
      end
      @(negedge clk);
      tab_we = 1'b0;
   endtask

   task automatic run_case(input string tag, input bit reload, input bit poke_tab,
                           input bit poke_start);
      int exp = dot();
      if (reload) load_table();
      for (int k = 0; k < N; k++) begin
         coef_in[k*CW +: CW] = CW'(cs[k]);
         samp_in[k*XW +: XW] = XW'(xs[k]);
      end
      @(negedge clk);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      for (int s = 1; s <= CW; s++) begin
         @(posedge clk); #1;
         tab_we = 1'b0;
         start = 1'b0;
         chk(done0 == (s == CW), {"R5 done u0 ", tag}, int'(done0), int'(s == CW));
         chk(done1 == (s == CW/2), {"R9 done u1 ", tag}, int'(done1), int'(s == CW/2));
         if (s == CW/2)
            chk(int'($signed(y1)) == exp, {"R9 R1 y u1 ", tag}, int'($signed(y1)), exp);
         if (s == CW)
            chk(int'($signed(y0)) == exp, {"R1 R4 y u0 ", tag}, int'($signed(y0)), exp);
         if (s == 2) begin
            // R7 / R8: disturbances inside the run, sampled on edge 3
            if (poke_tab) begin
               tab_we = 1'b1; tab_addr = '0; tab_data = EW'(12345);
            end
            if (poke_start) start = 1'b1;
         end
      end
      @(posedge clk); #1;
      chk(done0 == 1'b0, {"R6 done low u0 ", tag}, int'(done0), 0);
      chk(int'($signed(y0)) == exp, {"R6 y held u0 ", tag}, int'($signed(y0)), exp);
   endtask

   initial begin
      #(CLK_NS * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1;
      chk(done0 == 1'b0, "R10 done reset", int'(done0), 0);
      chk(y0 == '0, "R10 y reset", int'(y0), 0);
      @(negedge clk); rst_n = 1'b1;

      // R2: single tap selects the table addressing of tap 0
      cs = '{1, 0, 0, 0}; xs = '{37, -5, 9, 100};
      run_case("R2 tap0", 1'b1, 1'b0, 1'b0);
      // R3: negative last tap drives every slice into the mirrored half
      cs = '{0, 0, 0, -1}; xs = '{11, -22, 33, -44};
      run_case("R3 allfold", 1'b1, 1'b0, 1'b0);
      // R4: extreme coefficients and samples
      cs = '{-128, -128, -128, -128}; xs = '{-128, -128, -128, -128};
      run_case("R4 minmin", 1'b1, 1'b0, 1'b0);
      cs = '{127, -128, 127, -128}; xs = '{-128, 127, 127, -128};
      run_case("R4 mixed", 1'b1, 1'b0, 1'b0);
      // R7 and R8: write and start during the run, then rerun without reload
      cs = '{-77, 45, 3, -120}; xs = '{66, -99, 12, 101};
      run_case("R7 R8 poke", 1'b1, 1'b1, 1'b1);
      run_case("R7 reuse", 1'b0, 1'b0, 1'b0);

      for (int t = 0; t < 12; t++) begin
         for (int k = 0; k < N; k++) begin
            cs[k] = int'($urandom_range(255)) - 128;
            xs[k] = int'($urandom_range(255)) - 128;
         end
         run_case("R1 R3 random", 1'b1, 1'b0, 1'b0);
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule